// File: doc/BRIEF.md
# Back-porch clamp pulse generator

This block produces a clamp-gating pulse once per video line for the input black-level clamp of a video front end. It runs on a pixel-domain reference clock and takes the already synchronised horizontal sync and blanking levels. A pulse is started either by an edge of the horizontal sync or by the start of blanking. It then stays high for a programmed number of reference-clock cycles. A pass-through mode copies the sync level straight to the clamp output for systems that already supply a clamp pulse.

The polarity of the horizontal sync is found automatically. Over each line, from one rising edge of the sync input to the next, the block counts the cycles spent high and the cycles spent low. The shorter phase is taken as the active sync level. The pulse output stays low until the first full line has given a decision. Two configuration bytes set the behaviour. The mode byte holds the trigger source, the sync edge, the width code and the pass-through mode. The auxiliary byte holds the blanking polarity and whether the pulse is also sent to the output sample-and-hold strobe, which lets a system run with no blanking input.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `clamp_o`, `strobe_o` and `hs_pol_o` are all 0.
- R2: At every rising edge of `hsync_i` after the first one, `hs_pol_o` is updated on the next cycle. It becomes 1 (active high) if the cycles counted high since the previous rising edge are strictly fewer than the cycles counted low; otherwise it becomes 0 (active low). It does not change at any other time.
- R3: With `mode_cfg[0]`=0 and `mode_cfg[1]`=0, a pulse starts on the trailing edge of the active sync level: the return of `hsync_i` to its inactive level.
- R4: With `mode_cfg[0]`=0 and `mode_cfg[1]`=1, a pulse starts on the leading edge of the active sync level.
- R5: With `mode_cfg[0]`=1, a pulse starts when blanking becomes active. `aux_cfg[0]`=0 means blanking is active high and `aux_cfg[0]`=1 means it is active low.
- R6: `mode_cfg[3:2]` sets the pulse length to 8, 16, 32 or 64 cycles for codes 0, 1, 2 and 3. If the edge is present on the inputs at clock edge t, `clamp_o` is high for exactly that many cycles, starting right after t.
- R7: A trigger edge that arrives while a pulse is still high is ignored. It neither extends nor restarts the pulse.
- R8: With `mode_cfg[4]`=1, `clamp_o` equals the `hsync_i` level combinationally (raw polarity) and no timed pulse is started.
- R9: With `aux_cfg[7]`=1, `strobe_o` equals `clamp_o`. With `aux_cfg[7]`=0, `strobe_o` is 0.
- R10: Until the first polarity decision after reset, `clamp_o` is 0 in every mode, pass-through included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Synchronised horizontal sync level, either polarity |
| blank_i | input | 1 | Synchronised blanking level |
| mode_cfg | input | 8 | Bit 0 source (0 sync, 1 blanking), bit 1 sync edge (0 trailing, 1 leading), bits 3:2 width code, bit 4 pass-through |
| aux_cfg | input | 8 | Bit 0 blanking active low, bit 7 route the pulse to the sample strobe |
| clamp_o | output | 1 | Clamp-gating pulse |
| strobe_o | output | 1 | Output sample-and-hold strobe |
| hs_pol_o | output | 1 | Detected sync polarity, 1 for active high |

## Verification
The sync input is driven with short-high lines and then with short-low lines. This shows whether the polarity decision follows the shorter phase and whether the edge selection follows that polarity. Each edge choice and each width code is run on lines long enough for the whole pulse, and then on lines shorter than a 64-cycle pulse, so that a pulse which is extended or restarted is caught. Blanking is used as the trigger with both polarities. Pass-through and strobe routing are switched on and off while lines keep running. A behavioural model is compared with the outputs on every cycle, and this also checks the quiet first line after reset.

// File: rtl/clp_pkg.sv
package clp_pkg;

    typedef enum logic {
        SRC_SYNC  = 1'b0,
        SRC_BLANK = 1'b1
    } trig_src_e;

    typedef struct packed {
        trig_src_e  src;
        logic       lead_edge;
        logic [1:0] width_code;
        logic       bypass;
        logic       blank_low;
        logic       strobe_en;
    } clp_cfg_t;

    function automatic clp_cfg_t decode_cfg(input logic [7:0] mode_b, input logic [7:0] aux_b);
        clp_cfg_t c;
        c.src        = trig_src_e'(mode_b[0]);
        c.lead_edge  = mode_b[1];
        c.width_code = mode_b[3:2];
        c.bypass     = mode_b[4];
        c.blank_low  = aux_b[0];
        c.strobe_en  = aux_b[7];
        return c;
    endfunction

    function automatic int unsigned pulse_len(input int unsigned base, input logic [1:0] code);
        return base << code;
    endfunction

endpackage

// File: rtl/clp_polarity_det.sv
module clp_polarity_det #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_i,
    output logic pol_o,
    output logic valid_o,
    output logic rise_o,
    output logic fall_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             hs_d;
    logic             seen_q;
    logic             pol_q;
    logic             valid_q;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;

    assign rise_o  = hs_i && !hs_d;
    assign fall_o  = !hs_i && hs_d;
    assign pol_o   = pol_q;
    assign valid_o = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_d    <= 1'b1;
            seen_q  <= 1'b0;
            pol_q   <= 1'b0;
            valid_q <= 1'b0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
        end else begin
            hs_d <= hs_i;
            if (rise_o) begin
                if (seen_q) begin
                    pol_q   <= (hi_cnt < lo_cnt);
                    valid_q <= 1'b1;
                end
                seen_q <= 1'b1;
                hi_cnt <= CNT_W'(1);
                lo_cnt <= '0;
            end else if (hs_i) begin
                if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                if (lo_cnt != CNT_MAX) lo_cnt <= lo_cnt + 1'b1;
            end
        end
    end

    // R2
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q);

    // R2
    pol_only_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !rise_o |=> $stable(pol_q));

endmodule

// File: rtl/clp_trig_sel.sv
module clp_trig_sel
    import clp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clp_cfg_t cfg_i,
    input  logic     pol_i,
    input  logic     hs_rise_i,
    input  logic     hs_fall_i,
    input  logic     blank_i,
    output logic     trig_o
);
    logic blank_act;
    logic blank_prev;
    logic sync_lead;
    logic sync_trail;
    logic blank_lead;

    always_comb begin
        blank_act  = cfg_i.blank_low ? !blank_i : blank_i;
        blank_lead = blank_act && !blank_prev;
        sync_lead  = pol_i ? hs_rise_i : hs_fall_i;
        sync_trail = pol_i ? hs_fall_i : hs_rise_i;
        unique case (cfg_i.src)
            SRC_BLANK: trig_o = blank_lead;
            default:   trig_o = cfg_i.lead_edge ? sync_lead : sync_trail;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) blank_prev <= 1'b1;
        else     blank_prev <= blank_act;
    end

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sync_lead, sync_trail}));

endmodule

// File: rtl/clp_pulse_timer.sv
module clp_pulse_timer
    import clp_pkg::*;
#(
    parameter int BASE_LEN = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] code_i,
    output logic       active_o
);
    localparam int MAX_LEN = BASE_LEN * 8;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic             active_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] load_val;

    assign load_val = LEN_W'(pulse_len(BASE_LEN, code_i) - 1);
    assign active_o = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!active_q) begin
            if (start_i) begin
                active_q <= 1'b1;
                cnt_q    <= load_val;
            end
        end else if (cnt_q == '0) begin
            active_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R6
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && cnt_q != '0) |=> active_q);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !start_i) |=> !active_q);

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import clp_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int BASE_LEN = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_i,
    input  logic       blank_i,
    input  logic [7:0] mode_cfg,
    input  logic [7:0] aux_cfg,
    output logic       clamp_o,
    output logic       strobe_o,
    output logic       hs_pol_o
);
    clp_cfg_t cfg;
    logic     pol;
    logic     pol_valid;
    logic     hs_rise;
    logic     hs_fall;
    logic     trig;
    logic     start;
    logic     pulse_act;

    assign cfg = decode_cfg(mode_cfg, aux_cfg);

    clp_polarity_det #(.CNT_W(CNT_W)) det_i (
        .clk     (clk),
        .rst     (rst),
        .hs_i    (hsync_i),
        .pol_o   (pol),
        .valid_o (pol_valid),
        .rise_o  (hs_rise),
        .fall_o  (hs_fall)
    );

    clp_trig_sel trig_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg),
        .pol_i     (pol),
        .hs_rise_i (hs_rise),
        .hs_fall_i (hs_fall),
        .blank_i   (blank_i),
        .trig_o    (trig)
    );

    assign start = trig && pol_valid && !cfg.bypass;

    clp_pulse_timer #(.BASE_LEN(BASE_LEN)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .code_i   (cfg.width_code),
        .active_o (pulse_act)
    );

    always_comb begin
        clamp_o  = pol_valid && (cfg.bypass ? hsync_i : pulse_act);
        strobe_o = cfg.strobe_en && clamp_o;
    end

    assign hs_pol_o = pol;

    // R10
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pol_valid |-> !clamp_o);

    // R9
    strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !aux_cfg[7] |-> !strobe_o);

endmodule

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb_top;

    localparam int CNT_W    = 10;
    localparam int BASE_LEN = 8;
    localparam int CMAX     = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_i = 1'b0;
    logic blank_i = 1'b0;
    logic [7:0] mode_cfg = 8'h00;
    logic [7:0] aux_cfg  = 8'h00;
    logic clamp_o, strobe_o, hs_pol_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    always #2.5ns clk = ~clk;

    clamp_pulse_gen #(.CNT_W(CNT_W), .BASE_LEN(BASE_LEN)) dut_i (
        .clk(clk), .rst(rst), .hsync_i(hsync_i), .blank_i(blank_i),
        .mode_cfg(mode_cfg), .aux_cfg(aux_cfg),
        .clamp_o(clamp_o), .strobe_o(strobe_o), .hs_pol_o(hs_pol_o)
    );

    // behavioural reference state
    bit m_hs_prev, m_seen, m_pol, m_valid, m_act, m_bprev;
    int m_hi, m_lo, m_left;

    always @(posedge clk) begin
        bit rise, fall, lead, trail, hs_trig, bact, blead, trig, start;
        if (rst) begin
            m_hs_prev = 1; m_seen = 0; m_pol = 0; m_valid = 0;
            m_act = 0; m_bprev = 1; m_hi = 0; m_lo = 0; m_left = 0;
        end else begin
            rise    = hsync_i && !m_hs_prev;
            fall    = !hsync_i && m_hs_prev;
            lead    = m_pol ? rise : fall;
            trail   = m_pol ? fall : rise;
            hs_trig = mode_cfg[1] ? lead : trail;
            bact    = aux_cfg[0] ? !blank_i : blank_i;
            blead   = bact && !m_bprev;
            trig    = mode_cfg[0] ? blead : hs_trig;
            start   = trig && m_valid && !mode_cfg[4];
            if (m_act) begin
                m_left--;
                if (m_left == 0) m_act = 0;
            end else if (start) begin
                m_act  = 1;
                m_left = BASE_LEN << mode_cfg[3:2];
            end
            if (rise) begin
                if (m_seen) begin
                    m_pol   = (m_hi < m_lo);
                    m_valid = 1;
                end
                m_seen = 1; m_hi = 1; m_lo = 0;
            end else if (hsync_i) begin
                if (m_hi < CMAX) m_hi++;
            end else begin
                if (m_lo < CMAX) m_lo++;
            end
            m_hs_prev = hsync_i;
            m_bprev   = bact;
        end
    end

    task automatic compare();
        bit exp_clamp, exp_strobe;
        exp_clamp  = m_valid && (mode_cfg[4] ? hsync_i : m_act);
        exp_strobe = aux_cfg[7] && exp_clamp;
        checks++;
        if (clamp_o !== exp_clamp) begin
            fails++;
            $display("FAIL %s clamp_o got %b expected %b at %0t", cur_req, clamp_o, exp_clamp, $time);
        end
        checks++;
        if (strobe_o !== exp_strobe) begin
            fails++;
            $display("FAIL %s strobe_o got %b expected %b at %0t", cur_req, strobe_o, exp_strobe, $time);
        end
        checks++;
        if (hs_pol_o !== m_pol) begin
            fails++;
            $display("FAIL %s hs_pol_o got %b expected %b at %0t", cur_req, hs_pol_o, m_pol, $time);
        end
    endtask

    task automatic tick(input logic hs, input logic bl);
        @(negedge clk);
        compare();
        hsync_i = hs;
        blank_i = bl;
    endtask

    // one line: sync high for hi cycles then low for lo; blanking active from bs for bn cycles
    task automatic line(input int hi, input int lo, input int bs, input int bn, input bit blow);
        for (int i = 0; i < hi + lo; i++) begin
            logic bl;
            bl = (i >= bs && i < bs + bn);
            tick(i < hi, blow ? !bl : bl);
        end
    endtask

    task automatic lines(input int n, input int hi, input int lo);
        for (int k = 0; k < n; k++) line(hi, lo, 0, 0, aux_cfg[0]);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        tick(1'b0, 1'b0);
        checks++;
        if (clamp_o !== 1'b0 || strobe_o !== 1'b0 || hs_pol_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 outputs got %b%b%b expected 000", clamp_o, strobe_o, hs_pol_o);
        end

        // R10 and R3: first line must stay quiet, then trailing-edge pulses
        cur_req = "R10";
        aux_cfg = 8'h80;
        line(10, 90, 0, 0, 0);
        cur_req = "R3";
        lines(3, 10, 90);
        // R2: positive sync gives active high
        cur_req = "R2";
        checks++;
        if (hs_pol_o !== 1'b1) begin
            fails++;
            $display("FAIL R2 hs_pol_o got %b expected 1", hs_pol_o);
        end

        // R4: leading edge
        cur_req = "R4";
        mode_cfg = 8'h02;
        lines(3, 10, 90);

        // R6: each width code, lines long enough for 64
        cur_req = "R6";
        for (int c = 0; c < 4; c++) begin
            mode_cfg = {4'h0, c[1:0], 2'b00};
            lines(2, 12, 140);
        end

        // R2: negative sync flips the polarity and the edges
        cur_req = "R2";
        mode_cfg = 8'h04;
        lines(4, 90, 12);
        checks++;
        if (hs_pol_o !== 1'b0) begin
            fails++;
            $display("FAIL R2 hs_pol_o got %b expected 0", hs_pol_o);
        end
        cur_req = "R4";
        mode_cfg = 8'h06;
        lines(3, 90, 12);

        // R5: blanking source, active high then active low
        cur_req = "R5";
        lines(2, 10, 90);
        mode_cfg = 8'h01;
        aux_cfg  = 8'h80;
        for (int k = 0; k < 3; k++) line(10, 90, 70, 20, 0);
        aux_cfg  = 8'h81;
        for (int k = 0; k < 3; k++) line(10, 90, 60, 25, 1);

        // R7: 64-cycle pulses on 40-cycle lines
        cur_req = "R7";
        aux_cfg  = 8'h80;
        mode_cfg = 8'h0C;
        lines(6, 4, 36);
        mode_cfg = 8'h0E;
        lines(4, 4, 36);

        // R8: pass-through
        cur_req = "R8";
        mode_cfg = 8'h10;
        lines(3, 10, 50);
        mode_cfg = 8'h00;
        lines(2, 10, 90);

        // R9: strobe disabled then enabled
        cur_req = "R9";
        aux_cfg = 8'h00;
        lines(3, 10, 90);
        mode_cfg = 8'h10;
        lines(2, 10, 50);
        aux_cfg = 8'h80;
        lines(2, 10, 50);

        // R10: second reset, pass-through must stay low during the first line
        cur_req = "R10";
        @(negedge clk);
        rst = 1'b1;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        rst = 1'b0;
        line(10, 40, 0, 0, 0);
        lines(2, 10, 40);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5ns);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule